// File: doc/BRIEF.md
# SMBus Byte Memory Target with Locked and Scratch Halves

This block is an SMBus target that serves a byte array split into two halves of equal size. The lower half is an information area that no bus transaction can change. The upper half is a scratch area that the host may rewrite unless a write-protect pin is high. The host selects a location with an 8-bit command byte. The top bit of that byte picks the half, and the bits below it pick the byte within the half.

The target handles only the Read Byte and Write Byte packet types. It watches the open-drain SCL and SDA lines through two-flop synchronizers and finds start and stop conditions. It matches a 7-bit address set by a parameter, shifts bits in on rising SCL, and shifts its own bits out on falling SCL. A write that protection blocks is still acknowledged at every byte, so the host cannot see the difference, but the data is dropped. At reset the information half is loaded with computed contents that include a checksum byte, and the scratch half is filled with FFh.

Top module: `smb_tgt`

## Requirements
- R1: A stop condition (SDA rising while SCL is high) ends any transfer in progress and releases SDA. A start condition (SDA falling while SCL is high) begins a new address phase. A Write Byte cut short by a stop before its ninth data clock leaves memory unchanged.
- R2: The target acknowledges only its parameter address (default 50h). When any other address is sent, it returns no ACK and leaves SDA released for the rest of the transfer, so the later bytes are not acknowledged and read data comes back as FFh.
- R3: A Write Byte of address+W, offset and data is acknowledged at all three bytes. When the offset has bit 7 = 1 and write-protect is low, the data byte is stored at that offset.
- R4: A Read Byte (address+W, offset, repeated start, address+R) returns the byte stored at that offset, MSB first. The target changes the data bits while SCL is low, and the host ends with a NACK and a stop.
- R5: Offsets with bit 7 = 0 (00h–7Fh) are read-only. A Write Byte to them is acknowledged at all three bytes, but the stored byte does not change.
- R6: While the active-high write-protect input is high, a Write Byte to offsets 80h–FFh is acknowledged at all three bytes but stores nothing. Once the input is low, the same write takes effect.
- R7: After reset, information byte i (i = 00h–7Fh, i ≠ 7Ch) holds (29·i + 5Ah) mod 256, and every scratch byte holds FFh.
- R8: Information byte 7Ch holds the two's complement of the 8-bit sum of the other 127 information bytes, so the 128 information bytes sum to 00h mod 256.
- R9: The target changes its SDA pull-down only while SCL is low.
- R10: A Write Byte carries exactly one data byte. A second data byte sent before the stop is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset; reloads the array |
| scl_i | input | 1 | SMBus clock line as seen on the bus |
| sda_i | input | 1 | SMBus data line as seen on the bus (wired-AND value) |
| wp_i | input | 1 | Write-protect for the scratch half, active high |
| sda_oe_o | output | 1 | When 1, pull SDA low (ACK or a data bit of 0) |

## Verification
On every cycle, the assertions check three things. The information half never changes. No scratch byte changes in the cycle after write-protect was high. The SDA pull-down moves only after SCL was seen low, and it is released when the target is idle or ignoring the bus or has just seen a stop. Other behaviour can only be shown by the bench's transactions: the address match, the stored value after a permitted write, the reset contents and checksum, the single-data-byte limit, and the abort of a partly sent byte. The bench reads back every offset after reset and compares each one with values it computes itself.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_CMD,
      ST_ACK_CMD,
      ST_WDATA,
      ST_ACK_WDATA,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } smb_state_e;
endpackage

// File: rtl/smb_tgt_sync.sv
module smb_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smb_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smb_tgt_cond.sv
module smb_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_tgt_mem.sv
module smb_tgt_mem
   import smb_tgt_pkg::*;
#(
   parameter int AW           = 8,
   parameter int FILL_MULT    = 29,
   parameter int FILL_BASE    = 'h5A,
   parameter int SCRATCH_FILL = 'hFF,
   parameter int CSUM_OFF     = 'h7C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wp_i
);
   localparam int DEPTH = 1 << AW;
   localparam int HALF  = DEPTH / 2;

   function automatic logic [BYTE_W-1:0] info_byte(int idx);
      return BYTE_W'(idx * FILL_MULT + FILL_BASE);
   endfunction

   function automatic logic [BYTE_W-1:0] info_csum();
      logic [BYTE_W-1:0] acc;
      acc = '0;
      for (int k = 0; k < HALF; k++)
         if (k != CSUM_OFF) acc = acc + info_byte(k);
      return ~acc + 1'b1;
   endfunction

   localparam logic [BYTE_W-1:0] CSUM = info_csum();

   logic [BYTE_W-1:0] store [DEPTH];
   logic              wr_allowed;

   // Upper half only, and only while the protect pin is low.
   assign wr_allowed = wr_addr[AW-1] & ~wp_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) begin
            if (k >= HALF)          store[k[AW-1:0]] <= BYTE_W'(SCRATCH_FILL);
            else if (k == CSUM_OFF) store[k[AW-1:0]] <= CSUM;
            else                    store[k[AW-1:0]] <= info_byte(k);
         end
      end else if (wr_en && wr_allowed) begin
         store[wr_addr] <= wr_data;
      end
   end

   assign rd_data = store[rd_addr];
endmodule

// File: rtl/smb_tgt.sv
module smb_tgt
   import smb_tgt_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR     = 7'h50,
   parameter int         AW           = 8,
   parameter int         SYNC_STAGES  = 2,
   parameter int         FILL_MULT    = 29,
   parameter int         FILL_BASE    = 'h5A,
   parameter int         SCRATCH_FILL = 'hFF,
   parameter int         CSUM_OFF     = 'h7C
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wp_i,
   output logic sda_oe_o
);
   localparam int CNT_W = 4;
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   generate
      if (AW < 2 || AW > BYTE_W) begin : g_bad_aw
         $error("smb_tgt: AW must lie in 2..8");
      end
      if (CSUM_OFF >= (1 << (AW - 1))) begin : g_bad_csum
         $error("smb_tgt: CSUM_OFF must lie in the information half");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_c, stop_c;

   smb_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   smb_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   smb_tgt_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c));

   smb_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic [AW-1:0]     ptr;
   logic              rw;
   logic [BYTE_W-1:0] rd_data;
   logic              wr_en;

   // Commit at the falling edge that closes the eighth data bit.
   assign wr_en = (st == ST_WDATA) && scl_fall && (cnt == FULL) && !start_c && !stop_c;

   smb_tgt_mem #(
      .AW(AW), .FILL_MULT(FILL_MULT), .FILL_BASE(FILL_BASE),
      .SCRATCH_FILL(SCRATCH_FILL), .CSUM_OFF(CSUM_OFF)
   ) u_mem (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(ptr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
      .wp_i(wp_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         ptr      <= '0;
         rw       <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (start_c) begin
         st       <= ST_ADDR;
         cnt      <= '0;
         sda_oe_o <= 1'b0;
      end else if (stop_c) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         sda_oe_o <= 1'b0;
      end else begin
         if (scl_rise) begin
            case (st)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (cnt != FULL) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end
               end
               ST_RACK: st <= ST_IGNORE;
               default: ;
            endcase
         end
         if (scl_fall) begin
            case (st)
               ST_ADDR: begin
                  if (cnt == FULL) begin
                     if (shreg[BYTE_W-1:1] == TGT_ADDR) begin
                        st       <= ST_ACK_ADDR;
                        rw       <= shreg[0];
                        sda_oe_o <= 1'b1;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               ST_ACK_ADDR: begin
                  if (!rw) begin
                     st       <= ST_CMD;
                     cnt      <= '0;
                     sda_oe_o <= 1'b0;
                  end else begin
                     st       <= ST_RDATA;
                     cnt      <= CNT_W'(1);
                     shreg    <= rd_data;
                     sda_oe_o <= ~rd_data[BYTE_W-1];
                  end
               end
               ST_CMD: begin
                  if (cnt == FULL) begin
                     ptr      <= shreg[AW-1:0];
                     st       <= ST_ACK_CMD;
                     sda_oe_o <= 1'b1;
                  end
               end
               ST_ACK_CMD: begin
                  st       <= ST_WDATA;
                  cnt      <= '0;
                  sda_oe_o <= 1'b0;
               end
               ST_WDATA: begin
                  if (cnt == FULL) begin
                     st       <= ST_ACK_WDATA;
                     sda_oe_o <= 1'b1;
                  end
               end
               ST_ACK_WDATA: begin
                  st       <= ST_IGNORE;
                  sda_oe_o <= 1'b0;
               end
               ST_RDATA: begin
                  if (cnt == FULL) begin
                     st       <= ST_RACK;
                     sda_oe_o <= 1'b0;
                  end else begin
                     sda_oe_o <= ~shreg[BYTE_W-2];
                     shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                     cnt      <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smb_tgt_chk.sv
module smb_tgt_chk
   import smb_tgt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_oe,
   input logic       start_c,
   input logic       stop_c,
   input smb_state_e st
);
   assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s));

   assert_quiet_when_unaddressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_IGNORE) |-> !sda_oe);

   assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> (st == ST_IDLE && !sda_oe));

   assert_start_rearms_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> (st == ST_ADDR && !sda_oe));
endmodule

module smb_tgt_mem_chk #(
   parameter int AW = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wp_i,
   input logic [7:0] store [1 << AW]
);
   localparam int HALF = (1 << AW) / 2;

   generate
      for (genvar j = 0; j < HALF; j++) begin : g_info
         assert_info_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(store[j]));
      end
      for (genvar j = HALF; j < 2 * HALF; j++) begin : g_scratch
         assert_wp_holds_scratch_R6: assert property (@(posedge clk) disable iff (!rst_n)
            wp_i |=> $stable(store[j]));
      end
   endgenerate
endmodule

bind smb_tgt smb_tgt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
   .start_c(start_c), .stop_c(stop_c), .st(st));

bind smb_tgt_mem smb_tgt_mem_chk #(.AW(AW)) u_mchk (
   .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .store(store));

// File: tb/smb_tgt_tb.sv
module smb_tgt_tb_top;
   localparam int Q = 3;
   localparam logic [6:0] ADDR = 7'h50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1;
   logic sda_h = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   logic sda_bus;

   int n_tests = 0;
   int n_fail = 0;
   int r9_viol = 0;
   bit done = 1'b0;
   logic oe_prev = 1'b0;
   logic [7:0] model [256];

   always #5 clk = ~clk;

   assign sda_bus = sda_h & ~sda_oe;

   smb_tgt dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
      .wp_i(wp), .sda_oe_o(sda_oe));

   // R9 monitor: a change of the pull-down while SCL is high is a violation
   always @(posedge clk) begin
      #1;
      if (rst_n && (sda_oe !== oe_prev) && scl_h) r9_viol++;
      oe_prev = sda_oe;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; qw(); scl_h = 1'b1; qw(); sda_h = 1'b0; qw(); scl_h = 1'b0; qw();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; qw(); scl_h = 1'b1; qw(); sda_h = 1'b1; qw();
   endtask

   task automatic bus_bit(input logic b, output logic s);
      sda_h = b; qw(); scl_h = 1'b1; qw(); s = sda_bus; qw(); scl_h = 1'b0; qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         d[i] = s;
      end
      bus_bit(1'b1, s);
   endtask

   task automatic write_txn(input logic [6:0] a, input logic [7:0] off, input logic [7:0] dat,
                            input bit extra, input logic [7:0] dat2,
                            output logic [2:0] acks, output logic ack2);
      bus_start();
      send_byte({a, 1'b0}, acks[2]);
      send_byte(off, acks[1]);
      send_byte(dat, acks[0]);
      ack2 = 1'b0;
      if (extra) send_byte(dat2, ack2);
      bus_stop();
   endtask

   task automatic read_txn(input logic [6:0] a, input logic [7:0] off,
                           output logic [2:0] acks, output logic [7:0] d);
      bus_start();
      send_byte({a, 1'b0}, acks[2]);
      send_byte(off, acks[1]);
      bus_start();
      send_byte({a, 1'b1}, acks[0]);
      recv_byte(d);
      bus_stop();
   endtask

   task automatic expect_read(input string req, input logic [7:0] off);
      logic [2:0] acks;
      logic [7:0] d;
      read_txn(ADDR, off, acks, d);
      check({req, " read acks"}, 32'(acks), 32'h7);
      check({req, " read data"}, 32'(d), 32'(model[off]));
   endtask

   task automatic expect_write(input string req, input logic [7:0] off, input logic [7:0] dat);
      logic [2:0] acks;
      logic a2;
      write_txn(ADDR, off, dat, 1'b0, 8'h00, acks, a2);
      check({req, " write acks"}, 32'(acks), 32'h7);
      if (off[7] && !wp) model[off] = dat;
   endtask

   initial begin
      logic [7:0] sum;
      for (int i = 0; i < 128; i++) model[i] = 8'((i * 29 + 'h5A) % 256);
      sum = 8'h00;
      for (int i = 0; i < 128; i++) if (i != 'h7C) sum = sum + model[i];
      model['h7C] = 8'(256 - int'(sum)) ;
      for (int i = 128; i < 256; i++) model[i] = 8'hFF;
   end

   initial begin
      logic [2:0] acks;
      logic a2, s;
      logic [7:0] d;
      logic [7:0] isum;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: released after reset
      check("R1 reset release", 32'(sda_oe), 32'h0);

      // R7 R8 R4: sweep every offset after reset
      isum = 8'h00;
      for (int off = 0; off < 256; off++) begin
         read_txn(ADDR, 8'(off), acks, d);
         check("R2 sweep acks", 32'(acks), 32'h7);
         check(off < 128 ? "R7 info contents" : "R7 scratch contents", 32'(d), 32'(model[off]));
         if (off < 128) isum = isum + d;
      end
      check("R8 info bytes sum to zero", 32'(isum), 32'h0);

      // R3: scratch writes with several patterns
      expect_write("R3", 8'h80, 8'h00);
      expect_write("R3", 8'h81, 8'h5A);
      expect_write("R3", 8'hA5, 8'hC3);
      expect_write("R3", 8'hFF, 8'h81);
      expect_read("R3", 8'h80);
      expect_read("R3", 8'h81);
      expect_read("R4", 8'hA5);
      expect_read("R4", 8'hFF);

      // R5: info half is read-only but writes are acknowledged
      expect_write("R5", 8'h00, 8'h11);
      expect_write("R5", 8'h7C, 8'h22);
      expect_write("R5", 8'h7F, 8'h33);
      expect_read("R5", 8'h00);
      expect_read("R5", 8'h7C);
      expect_read("R5", 8'h7F);

      // R6: write-protect blocks scratch writes
      wp = 1'b1;
      expect_write("R6", 8'h90, 8'h3C);
      expect_write("R6", 8'hA5, 8'h00);
      expect_read("R6", 8'h90);
      expect_read("R6", 8'hA5);
      wp = 1'b0;
      expect_write("R6", 8'h90, 8'h3C);
      expect_read("R6", 8'h90);

      // R10: second data byte refused
      write_txn(ADDR, 8'hC0, 8'h12, 1'b1, 8'h34, acks, a2);
      check("R10 first bytes acked", 32'(acks), 32'h7);
      check("R10 second data not acked", 32'(a2), 32'h0);
      model[8'hC0] = 8'h12;
      expect_read("R10", 8'hC0);
      expect_read("R10", 8'hC1);

      // R2: foreign address ignored
      read_txn(7'h51, 8'h80, acks, d);
      check("R2 foreign acks", 32'(acks), 32'h0);
      check("R2 foreign data released", 32'(d), 32'hFF);
      write_txn(7'h28, 8'h82, 8'h00, 1'b0, 8'h00, acks, a2);
      check("R2 foreign write acks", 32'(acks), 32'h0);
      expect_read("R2", 8'h82);

      // R1: stop in the middle of the offset byte
      bus_start();
      send_byte({ADDR, 1'b0}, a2);
      for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
      bus_stop();
      check("R1 abort released", 32'(sda_oe), 32'h0);
      expect_read("R1", 8'h80);
      // R1: stop in the middle of the data byte leaves memory unchanged
      bus_start();
      send_byte({ADDR, 1'b0}, a2);
      send_byte(8'hD0, a2);
      for (int i = 0; i < 5; i++) bus_bit(1'b0, s);
      bus_stop();
      expect_read("R1", 8'hD0);

      check("R9 pull-down changed with SCL high", 32'(r9_viol), 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule